// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block is the processor-side end of a priority interrupt scheme. It receives the winning external source, a source number with an 8-bit priority, from a separate source controller. It holds two priority registers that software writes over a simple word-indexed register bus. The first is the current processor priority, which acts as a threshold. The second is a software interrupt request register, used to signal one processor from another. The block compares the two candidates with the threshold and drives one interrupt line to the core.

Lower numbers are more favored. The value 0xFF means "no request". A request reaches the core only if its priority is strictly below the threshold. Software takes an interrupt by reading the pending-interrupt word. That read returns the old threshold and the vector, and it raises the threshold to the priority of the interrupt taken. Writing the pending-interrupt word back ends the interrupt: it restores the threshold, and if the vector is the software vector, it also withdraws the software request.

Top module: `irq_presenter`

## Requirements
- R1: After reset the threshold reads 0x00, the software request register reads 0xFF and `irq_o` is low.
- R2: While the threshold is 0x00, `irq_o` stays low whatever requests are pending.
- R3: A candidate is presented only if its priority is strictly less than the threshold. With threshold 6, priority 4 is presented and priority 6 is not. With threshold 7, priority 6 is presented.
- R4: Writing a byte below 0xFF to the software request register (word index 2) raises a request at that priority. Writing 0xFF withdraws it.
- R5: An external priority of 0xFF is treated as no external request.
- R6: When both candidates are requested, the lower priority number wins. On equal priorities the software request wins.
- R7: Reading word index 0 returns the threshold in bits 31:24 and the presented vector in bits 23:0. The vector is 2 for the software request, 16 plus the source number for an external source, and 0 when nothing is presented.
- R8: A read of word index 0 while an interrupt is presented sets the threshold to that interrupt's priority. Any read of word index 0 forces `irq_o` low on the next cycle.
- R9: A write to word index 0 loads the threshold from bits 31:24. If bits 23:0 equal 2, the software request register becomes 0xFF. Otherwise that register is unchanged.
- R10: The threshold (word index 1) and the software request register (word index 2) are written from data bits 7:0 and read back with bits 31:8 as zero.
- R11: `irq_o` is registered. It goes high on the first clock edge after the presentation condition becomes true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word index: 0 pending, 1 threshold, 2 software request |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| ext_src_i | input | 4 | Winning external source number |
| ext_prio_i | input | 8 | Priority of that source, 0xFF if none |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
A wrong threshold or software request value shows up at the ports in one of two ways. `irq_o` changes one cycle after the bad state forms, or the next read of the pending word returns a wrong top byte or vector in the same cycle. Acknowledge and end-of-interrupt sequences move the state in a single cycle. A fault in them therefore shows on `irq_o` one cycle later and on a read-back right after. The reference model checks `irq_o` on every cycle, so a divergence is caught at the first clock where it can be observed.

// File: rtl/icp_pkg.sv
package icp_pkg;
  localparam logic [1:0] A_PEND = 2'd0;
  localparam logic [1:0] A_THR  = 2'd1;
  localparam logic [1:0] A_IPI  = 2'd2;
endpackage

// File: rtl/icp_arb.sv
module icp_arb #(
  parameter int PRIO_W   = 8,
  parameter int SRC_W    = 4,
  parameter int VEC_W    = 24,
  parameter int IPI_VEC  = 2,
  parameter int EXT_BASE = 16
) (
  input  logic [PRIO_W-1:0] ipi_prio_i,
  input  logic [SRC_W-1:0]  ext_src_i,
  input  logic [PRIO_W-1:0] ext_prio_i,
  input  logic [PRIO_W-1:0] cur_prio_i,
  output logic [PRIO_W-1:0] win_prio_o,
  output logic [VEC_W-1:0]  win_vec_o,
  output logic              present_o
);
  localparam logic [PRIO_W-1:0] MASKED = '1;

  logic ipi_v, ext_v, take_ipi;

  always_comb begin
    ipi_v    = (ipi_prio_i != MASKED);
    ext_v    = (ext_prio_i != MASKED);
    // tie favours the software request
    take_ipi = ipi_v && (!ext_v || (ipi_prio_i <= ext_prio_i));
    if (take_ipi) begin
      win_prio_o = ipi_prio_i;
      win_vec_o  = VEC_W'(IPI_VEC);
    end else if (ext_v) begin
      win_prio_o = ext_prio_i;
      win_vec_o  = VEC_W'(EXT_BASE) + VEC_W'(ext_src_i);
    end else begin
      win_prio_o = MASKED;
      win_vec_o  = '0;
    end
    present_o = (win_prio_o < cur_prio_i);
  end
endmodule

// File: rtl/icp_regs.sv
module icp_regs #(
  parameter int PRIO_W  = 8,
  parameter int VEC_W   = 24,
  parameter int IPI_VEC = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pend_rd_i,
  input  logic                    pend_wr_i,
  input  logic                    thr_wr_i,
  input  logic                    ipi_wr_i,
  input  logic [PRIO_W+VEC_W-1:0] wdata_i,
  input  logic [PRIO_W-1:0]       win_prio_i,
  input  logic                    present_i,
  output logic [PRIO_W-1:0]       cur_prio_o,
  output logic [PRIO_W-1:0]       ipi_prio_o,
  output logic                    irq_o
);
  localparam int DATA_W = PRIO_W + VEC_W;
  localparam logic [PRIO_W-1:0] MASKED = '1;

  logic [PRIO_W-1:0] cur_q, ipi_q;
  logic              irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      ipi_q <= MASKED;
      irq_q <= 1'b0;
    end else begin
      irq_q <= present_i && !pend_rd_i;
      if (pend_rd_i && present_i) begin
        cur_q <= win_prio_i;
      end else if (pend_wr_i) begin
        cur_q <= wdata_i[DATA_W-1 -: PRIO_W];
      end else if (thr_wr_i) begin
        cur_q <= wdata_i[PRIO_W-1:0];
      end
      if (pend_wr_i && (wdata_i[VEC_W-1:0] == VEC_W'(IPI_VEC))) begin
        ipi_q <= MASKED;
      end else if (ipi_wr_i) begin
        ipi_q <= wdata_i[PRIO_W-1:0];
      end
    end
  end

  assign cur_prio_o = cur_q;
  assign ipi_prio_o = ipi_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter #(
  parameter int PRIO_W   = 8,
  parameter int SRC_W    = 4,
  parameter int VEC_W    = 24,
  parameter int IPI_VEC  = 2,
  parameter int EXT_BASE = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [1:0]              addr_i,
  input  logic [PRIO_W+VEC_W-1:0] wdata_i,
  output logic [PRIO_W+VEC_W-1:0] rdata_o,
  input  logic [SRC_W-1:0]        ext_src_i,
  input  logic [PRIO_W-1:0]       ext_prio_i,
  output logic                    irq_o
);
  import icp_pkg::*;
  localparam int DATA_W = PRIO_W + VEC_W;

  logic [PRIO_W-1:0] cur_prio, ipi_prio, win_prio;
  logic [VEC_W-1:0]  win_vec;
  logic              present;
  logic              pend_rd, pend_wr, thr_wr, ipi_wr;

  assign pend_rd = req_i && !we_i && (addr_i == A_PEND);
  assign pend_wr = req_i &&  we_i && (addr_i == A_PEND);
  assign thr_wr  = req_i &&  we_i && (addr_i == A_THR);
  assign ipi_wr  = req_i &&  we_i && (addr_i == A_IPI);

  icp_arb #(
    .PRIO_W(PRIO_W), .SRC_W(SRC_W), .VEC_W(VEC_W),
    .IPI_VEC(IPI_VEC), .EXT_BASE(EXT_BASE)
  ) u_arb (
    .ipi_prio_i(ipi_prio),
    .ext_src_i (ext_src_i),
    .ext_prio_i(ext_prio_i),
    .cur_prio_i(cur_prio),
    .win_prio_o(win_prio),
    .win_vec_o (win_vec),
    .present_o (present)
  );

  icp_regs #(
    .PRIO_W(PRIO_W), .VEC_W(VEC_W), .IPI_VEC(IPI_VEC)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_rd_i (pend_rd),
    .pend_wr_i (pend_wr),
    .thr_wr_i  (thr_wr),
    .ipi_wr_i  (ipi_wr),
    .wdata_i   (wdata_i),
    .win_prio_i(win_prio),
    .present_i (present),
    .cur_prio_o(cur_prio),
    .ipi_prio_o(ipi_prio),
    .irq_o     (irq_o)
  );

  always_comb begin
    unique case (addr_i)
      A_PEND:  rdata_o = {cur_prio, present ? win_vec : VEC_W'(0)};
      A_THR:   rdata_o = DATA_W'(cur_prio);
      A_IPI:   rdata_o = DATA_W'(ipi_prio);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/icp_chk.sv
module icp_chk #(
  parameter int PRIO_W  = 8,
  parameter int VEC_W   = 24,
  parameter int IPI_VEC = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_i,
  input logic                    we_i,
  input logic [1:0]              addr_i,
  input logic [PRIO_W+VEC_W-1:0] wdata_i,
  input logic [PRIO_W+VEC_W-1:0] rdata_o,
  input logic                    irq_o,
  input logic [PRIO_W-1:0]       cur_prio,
  input logic [PRIO_W-1:0]       ipi_prio,
  input logic [PRIO_W-1:0]       win_prio,
  input logic                    present
);
  localparam int DATA_W = PRIO_W + VEC_W;
  logic rd0, wr0;
  assign rd0 = req_i && !we_i && (addr_i == 2'd0);
  assign wr0 = req_i &&  we_i && (addr_i == 2'd0);

  AST_MASK_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_prio == '0) |=> !irq_o); // R2
  AST_IRQ_STRICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(win_prio < cur_prio)); // R3
  AST_ACK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd0 |=> !irq_o); // R8
  AST_ACK_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd0 && present) |=> (cur_prio == $past(win_prio))); // R8
  AST_EOI_CUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0 |=> (cur_prio == $past(wdata_i[DATA_W-1 -: PRIO_W]))); // R9
  AST_EOI_IPI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr0 && (wdata_i[VEC_W-1:0] == VEC_W'(IPI_VEC))) |=> (ipi_prio == '1)); // R9
  AST_RD_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd0) |-> (rdata_o[DATA_W-1 -: PRIO_W] == cur_prio)); // R7
endmodule

bind irq_presenter icp_chk #(
  .PRIO_W(PRIO_W), .VEC_W(VEC_W), .IPI_VEC(IPI_VEC)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .cur_prio(cur_prio),
  .ipi_prio(ipi_prio),
  .win_prio(win_prio),
  .present (present)
);

// File: tb/sim_irq_presenter.sv
`timescale 1ns/1ps
module sim_irq_presenter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = 2'd3;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  ext_src_i = '0;
  logic [7:0]  ext_prio_i = 8'hFF;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  // reference state
  int m_cur = 0, m_ipi = 255;
  bit m_irq = 0;

  always #2.5 clk_i = ~clk_i;

  irq_presenter u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .ext_src_i(ext_src_i), .ext_prio_i(ext_prio_i), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one bus cycle; model compared at every clock
  task automatic cyc(input bit rq, input bit we, input int a, input logic [31:0] wd,
                     input int src, input int prio, input string tag);
    int wp, wv;
    bit pres;
    logic [31:0] exp_rd;
    @(negedge clk_i);
    check(irq_o == m_irq, {tag, " irq"}, irq_o, m_irq);
    req_i = rq; we_i = we; addr_i = 2'(a); wdata_i = wd;
    ext_src_i = 4'(src); ext_prio_i = 8'(prio);
    #1;
    if (m_ipi != 255 && (prio == 255 || m_ipi <= prio)) begin wp = m_ipi; wv = 2; end
    else if (prio != 255) begin wp = prio; wv = 16 + src; end
    else begin wp = 255; wv = 0; end
    pres = wp < m_cur;
    case (a)
      0: exp_rd = {8'(m_cur), pres ? 24'(wv) : 24'd0};
      1: exp_rd = 32'(m_cur);
      2: exp_rd = 32'(m_ipi);
      default: exp_rd = 32'd0;
    endcase
    if (rq && !we) check(rdata_o == exp_rd, {tag, " rdata"}, rdata_o, exp_rd);
    @(posedge clk_i);
    m_irq = pres && !(rq && !we && a == 0);
    if (rq && !we && a == 0 && pres) m_cur = wp;
    if (rq && we && a == 0) begin
      m_cur = int'(wd[31:24]);
      if (wd[23:0] == 24'd2) m_ipi = 255;
    end
    if (rq && we && a == 1) m_cur = int'(wd[7:0]);
    if (rq && we && a == 2) m_ipi = int'(wd[7:0]);
  endtask

  task automatic idle(input int n, input int src, input int prio, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 3, 0, src, prio, tag);
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #12 rst_ni = 1'b1;
    // R1 reset values
    cyc(1, 0, 1, 0, 0, 255, "R1 thr");
    cyc(1, 0, 2, 0, 0, 255, "R1 ipi");
    // R2 everything masked at threshold 0
    idle(3, 3, 4, "R2");
    cyc(1, 0, 0, 0, 3, 4, "R2 pend");
    // R3 / R11 threshold 6, prio 4 presented
    cyc(1, 1, 1, 32'h0000_0006, 3, 4, "R3 thr6");
    idle(2, 3, 4, "R11");
    idle(3, 3, 6, "R3 equal");
    cyc(1, 1, 1, 32'h1234_5607, 3, 6, "R10 thr7");
    cyc(1, 0, 1, 0, 3, 6, "R10 rd");
    idle(2, 3, 6, "R3 thr7");
    // R5 no external
    idle(3, 3, 255, "R5");
    cyc(1, 0, 0, 0, 9, 255, "R5 pend");
    // R4 software request
    cyc(1, 1, 2, 32'hABCD_EF04, 0, 255, "R4 ipi");
    cyc(1, 0, 2, 0, 0, 255, "R10 ipi rd");
    idle(2, 0, 255, "R4");
    cyc(1, 0, 0, 0, 0, 255, "R8 ack ipi");
    idle(2, 0, 255, "R8");
    cyc(1, 0, 1, 0, 0, 255, "R8 cur");
    cyc(1, 1, 0, 32'h0700_0002, 0, 255, "R9 eoi ipi");
    cyc(1, 0, 2, 0, 0, 255, "R9 ipi clr");
    // R6 tie and ordering
    cyc(1, 1, 2, 32'h0000_0005, 7, 5, "R6 set");
    cyc(1, 0, 0, 0, 7, 5, "R6 tie");
    cyc(1, 0, 1, 0, 7, 3, "R6 dummy");
    cyc(1, 0, 0, 0, 7, 3, "R6 ext wins");
    cyc(1, 0, 1, 0, 7, 3, "R8 ext cur");
    cyc(1, 1, 0, 32'h0700_0017, 7, 3, "R9 eoi ext");
    cyc(1, 0, 2, 0, 7, 3, "R9 ipi kept");
    cyc(1, 1, 2, 32'h0000_00FF, 7, 255, "R4 clear");
    idle(2, 7, 255, "R4 none");
    cyc(1, 0, 0, 0, 7, 255, "R7 none");
    // R2 again with live requests
    cyc(1, 1, 2, 32'h0000_0001, 2, 0, "R2 set");
    cyc(1, 1, 1, 32'h0000_0000, 2, 0, "R2 mask");
    idle(3, 2, 0, "R2 masked");
    idle(1, 2, 0, "end");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule